// File: doc/BRIEF.md
# Power Delivery Ordered-Set Encoder and Detector

This block handles the four-symbol ordered sets that open a Power Delivery packet or signal a reset. Each ordered set is four 5-bit K-codes. The block has two independent halves.

The transmit half takes a 3-bit type code and presents that type's four K-codes one at a time. A downstream serializer takes each code with a symbol strobe. The receive half gathers already-decoded 5-bit symbols in groups of four. It compares each group with every ordered-set type that the enable mask allows. It reports the best match, and tolerates one corrupted K-code. A hard reset also raises its own one-cycle flag.

The line coding, the data symbol coding and the CRC are handled elsewhere in the physical layer.

Top module: `pd_ordset_codec`

## Requirements
- R1: The K-code values are Sync-1 = 0x18, Sync-2 = 0x11, Sync-3 = 0x06, RST-1 = 0x07, RST-2 = 0x19 and EOP = 0x0D. Each ordered set is packed as 20 bits, with the first K-code in bits 4:0 and the fourth in bits 19:15.
- R2: The type codes are 0 = SOP (S1,S1,S1,S2), 1 = SOP' (S1,S1,S3,S3), 2 = SOP'' (S1,S3,S1,S3), 3 = SOP'-Debug (S1,R2,R2,S3), 4 = SOP''-Debug (S1,R2,S3,S2), 5 = Cable Reset (R1,S1,R1,S3), 6 = Hard Reset (R1,R1,R1,R2) and 7 = none. The transmitter emits these sequences in the order listed.
- R3: After `tx_start` with a type code below 7, `tx_busy` rises on the next cycle and `tx_kcode` shows the first K-code. Each `sym_stb` while busy advances to the next K-code. On the cycle after the fourth strobe, `tx_done` is high for one cycle and `tx_busy` is low. While the block is idle, `tx_kcode` reads 0.
- R4: A `tx_start` while `tx_busy` is high has no effect on the ongoing sequence. A `tx_start` with type code 7 does not start a transmission.
- R5: Every fourth accepted receive symbol (`rx_sym_valid` high) produces a one-cycle `rx_det_valid` on the following cycle. `rx_type`, `rx_partial` and `rx_bad_idx` hold their values until the next result.
- R6: A group that matches an enabled type on all four K-codes reports that type, with `rx_partial` = 0 and `rx_bad_idx` = 0.
- R7: A group that matches an enabled type on exactly three K-codes reports that type, with `rx_partial` = 1. `rx_bad_idx` gives the position (0 to 3) of the mismatching K-code.
- R8: A four-of-four match wins over any three-of-four match. Among three-of-four matches, the lowest type code wins.
- R9: Bit n of `rx_enable` (n = 0..6) allows type n to be reported. Bits 8:7 have no effect. A group with no allowed match reports type 7, `rx_partial` = 0 and `rx_bad_idx` = 0.
- R10: `rx_hard_reset` is high for exactly the cycle in which a Hard Reset result (type 6, full or partial) is reported.
- R11: `rx_clear` discards any partly gathered group. Symbol counting restarts, and a symbol offered in the same cycle is dropped.
- R12: After reset the transmitter is idle with `tx_done` low. The receiver shows `rx_det_valid` = 0, `rx_type` = 7, `rx_partial` = 0, `rx_bad_idx` = 0 and `rx_hard_reset` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Begin emitting the ordered set selected by `tx_type` |
| tx_type | input | 3 | Type code of the ordered set to send |
| sym_stb | input | 1 | Consumes the K-code currently shown on `tx_kcode` |
| tx_kcode | output | 5 | K-code currently offered to the serializer |
| tx_busy | output | 1 | A sequence is in progress |
| tx_done | output | 1 | One-cycle pulse after the fourth K-code is consumed |
| rx_sym_valid | input | 1 | `rx_sym` carries a decoded symbol |
| rx_sym | input | 5 | Decoded 5-bit receive symbol |
| rx_clear | input | 1 | Restart grouping of receive symbols |
| rx_enable | input | 9 | Per-type reporting enable (bits 6:0 used) |
| rx_det_valid | output | 1 | One-cycle pulse when a group has been judged |
| rx_type | output | 3 | Reported type code (7 = none) |
| rx_partial | output | 1 | The match used only three of the four K-codes |
| rx_bad_idx | output | 3 | Position of the mismatching K-code |
| rx_hard_reset | output | 1 | One-cycle Hard Reset indication |

## Verification
The transmitter is driven through all seven types. Comparing each emitted sequence with the bench's own table separates packing-order faults from code-value faults.

The receiver gets the following groups:
- Clean sets, which show that exact matching works.
- Sets with one corrupted code at the first and at the last position, which test the position report.
- A group that is one code away from both SOP and SOP', which exposes the tie-break.
- The same group with SOP masked off, which shows that the enable mask reroutes the decision to the next candidate.

Hard Reset groups are tried both enabled and masked, to tell the flag apart from the type report. A group cut short by a clear shows that grouping restarts.

// File: rtl/pd_ordset_codec.sv
module pd_ordset_codec #(
  parameter int KW    = 5,
  parameter int NTYPE = 7,
  parameter int MASKW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [2:0]    tx_type,
  input  logic          sym_stb,
  output logic [KW-1:0] tx_kcode,
  output logic          tx_busy,
  output logic          tx_done,
  input  logic          rx_sym_valid,
  input  logic [KW-1:0] rx_sym,
  input  logic          rx_clear,
  input  logic [MASKW-1:0] rx_enable,
  output logic          rx_det_valid,
  output logic [2:0]    rx_type,
  output logic          rx_partial,
  output logic [2:0]    rx_bad_idx,
  output logic          rx_hard_reset
);
  localparam int SETW = 4 * KW;
  localparam logic [2:0] T_NONE = 3'd7;
  localparam logic [2:0] T_HARD = 3'd6;
  localparam logic [KW-1:0] S1 = KW'(5'h18), S2 = KW'(5'h11), S3 = KW'(5'h06);
  localparam logic [KW-1:0] R1 = KW'(5'h07), R2 = KW'(5'h19);

  function automatic logic [SETW-1:0] set_word(input logic [2:0] t);
    case (t)
      3'd0:    set_word = {S2, S1, S1, S1};
      3'd1:    set_word = {S3, S3, S1, S1};
      3'd2:    set_word = {S3, S1, S3, S1};
      3'd3:    set_word = {S3, R2, R2, S1};
      3'd4:    set_word = {S2, S3, R2, S1};
      3'd5:    set_word = {S3, R1, S1, R1};
      3'd6:    set_word = {R2, R1, R1, R1};
      default: set_word = '0;
    endcase
  endfunction

  logic [SETW-1:0] tx_word;
  logic [1:0]      tx_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_idx  <= '0;
      tx_busy <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!tx_busy) begin
        if (tx_start && tx_type != T_NONE) begin
          tx_word <= set_word(tx_type);
          tx_idx  <= '0;
          tx_busy <= 1'b1;
        end
      end else if (sym_stb) begin
        tx_idx <= tx_idx + 2'd1;
        if (tx_idx == 2'd3) begin
          tx_busy <= 1'b0;
          tx_done <= 1'b1;
        end
      end
    end
  end

  assign tx_kcode = tx_busy ? tx_word[tx_idx*KW +: KW] : '0;

  logic [3*KW-1:0] rx_hold;
  logic [1:0]      rx_pos;
  logic [SETW-1:0] rx_word;
  logic [NTYPE-1:0] full_hit, part_hit;
  logic [2:0]       miss_idx [NTYPE];

  assign rx_word = {rx_sym, rx_hold};

  for (genvar t = 0; t < NTYPE; t++) begin : g_cmp
    logic [SETW-1:0] ref_word;
    logic [3:0]      eq;
    assign ref_word = set_word(3'(t));
    for (genvar k = 0; k < 4; k++) begin : g_pos
      assign eq[k] = rx_word[k*KW +: KW] == ref_word[k*KW +: KW];
    end
    assign full_hit[t] = rx_enable[t] && (&eq);
    assign part_hit[t] = rx_enable[t] && ($countones(eq) == 3);
    always_comb begin
      miss_idx[t] = 3'd0;
      for (int k = 0; k < 4; k++)
        if (!eq[k]) miss_idx[t] = 3'(k);
    end
  end

  logic [2:0] pick_type, pick_idx;
  logic       pick_part;

  always_comb begin
    pick_type = T_NONE;
    pick_idx  = 3'd0;
    pick_part = 1'b0;
    for (int t = NTYPE - 1; t >= 0; t--) begin
      if (part_hit[t]) begin
        pick_type = 3'(t);
        pick_idx  = miss_idx[t];
        pick_part = 1'b1;
      end
    end
    for (int t = NTYPE - 1; t >= 0; t--) begin
      if (full_hit[t]) begin
        pick_type = 3'(t);
        pick_idx  = 3'd0;
        pick_part = 1'b0;
      end
    end
  end

  wire group_end = rx_sym_valid && !rx_clear && rx_pos == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold       <= '0;
      rx_pos        <= '0;
      rx_det_valid  <= 1'b0;
      rx_type       <= T_NONE;
      rx_partial    <= 1'b0;
      rx_bad_idx    <= '0;
      rx_hard_reset <= 1'b0;
    end else begin
      rx_det_valid  <= group_end;
      rx_hard_reset <= group_end && pick_type == T_HARD;
      if (rx_clear) begin
        rx_pos <= '0;
      end else if (rx_sym_valid) begin
        rx_pos <= rx_pos + 2'd1;
        if (rx_pos != 2'd3)
          rx_hold[rx_pos*KW +: KW] <= rx_sym;
      end
      if (group_end) begin
        rx_type    <= pick_type;
        rx_partial <= pick_part;
        rx_bad_idx <= pick_idx;
      end
    end
  end
endmodule

module pd_ordset_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_stb,
  input logic [4:0] tx_kcode,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       rx_sym_valid,
  input logic       rx_det_valid,
  input logic [2:0] rx_type,
  input logic       rx_partial,
  input logic [2:0] rx_bad_idx,
  input logic       rx_hard_reset
);
  p_done_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(tx_busy && sym_stb) && !tx_busy);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  p_kcode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !sym_stb) |=> tx_busy && $stable(tx_kcode));
  p_det_after_sym_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_det_valid |-> $past(rx_sym_valid));
  p_exact_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_det_valid && !rx_partial) |-> rx_bad_idx == 3'd0);
  p_partial_typed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_partial |-> rx_type != 3'd7 && rx_bad_idx < 3'd4);
  p_none_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_det_valid && rx_type == 3'd7) |-> !rx_partial && !rx_hard_reset);
  p_hard_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hard_reset |-> rx_det_valid && rx_type == 3'd6);
endmodule

bind pd_ordset_codec pd_ordset_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .tx_kcode(tx_kcode),
  .tx_busy(tx_busy), .tx_done(tx_done), .rx_sym_valid(rx_sym_valid),
  .rx_det_valid(rx_det_valid), .rx_type(rx_type), .rx_partial(rx_partial),
  .rx_bad_idx(rx_bad_idx), .rx_hard_reset(rx_hard_reset)
);

// File: tb/pd_ordset_codec_tb.sv
module pd_ordset_codec_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_start = 0, sym_stb = 0, rx_sym_valid = 0, rx_clear = 0;
  logic [2:0] tx_type = 0;
  logic [4:0] rx_sym = 0;
  logic [8:0] rx_enable = 9'h1ff;
  logic [4:0] tx_kcode;
  logic tx_busy, tx_done, rx_det_valid, rx_partial, rx_hard_reset;
  logic [2:0] rx_type, rx_bad_idx;
  int n_chk = 0, n_fail = 0;

  localparam logic [4:0] S1 = 5'h18, S2 = 5'h11, S3 = 5'h06, R1 = 5'h07, R2 = 5'h19, EOP = 5'h0D;

  pd_ordset_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_type(tx_type),
    .sym_stb(sym_stb), .tx_kcode(tx_kcode), .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_sym_valid(rx_sym_valid), .rx_sym(rx_sym), .rx_clear(rx_clear),
    .rx_enable(rx_enable), .rx_det_valid(rx_det_valid), .rx_type(rx_type),
    .rx_partial(rx_partial), .rx_bad_idx(rx_bad_idx), .rx_hard_reset(rx_hard_reset));

  always #10 clk = ~clk;

  function automatic logic [4:0] seq_code(input int t, input int k);
    logic [4:0] s [7][4] = '{'{S1,S1,S1,S2}, '{S1,S1,S3,S3}, '{S1,S3,S1,S3},
                             '{S1,R2,R2,S3}, '{S1,R2,S3,S2}, '{R1,S1,R1,S3},
                             '{R1,R1,R1,R2}};
    return s[t][k];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input int t);
    @(negedge clk); tx_start = 1; tx_type = 3'(t);
    @(negedge clk); tx_start = 0;
    check(tx_busy == 1, "R3 busy", tx_busy, 1);
    for (int k = 0; k < 4; k++) begin
      check(tx_kcode == seq_code(t, k), "R1 R2 kcode", tx_kcode, seq_code(t, k));
      if (k == 1) begin
        tx_start = 1; tx_type = 3'd6;
        @(negedge clk); tx_start = 0;
        check(tx_kcode == seq_code(t, k), "R4 start while busy", tx_kcode, seq_code(t, k));
      end
      sym_stb = 1;
      @(negedge clk); sym_stb = 0;
    end
    check(tx_done == 1 && tx_busy == 0, "R3 done", {tx_done, tx_busy}, 2);
    @(negedge clk);
    check(tx_done == 0 && tx_kcode == 0, "R3 done single", {tx_done, tx_kcode}, 0);
  endtask

  task automatic send_rx(input logic [4:0] a, b, c, d,
                         input int et, input bit ep, input int ei, input bit eh, input string req);
    logic [4:0] v [4];
    v = '{a, b, c, d};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rx_sym_valid = 1; rx_sym = v[k];
      if (k < 3) check(rx_det_valid == 0 || k == 0, {req, " no early det"}, rx_det_valid, 0);
    end
    @(negedge clk); rx_sym_valid = 0;
    check(rx_det_valid == 1, {req, " R5 det"}, rx_det_valid, 1);
    check(rx_type == 3'(et), {req, " type"}, rx_type, et);
    check(rx_partial == ep, {req, " partial"}, rx_partial, ep);
    check(rx_bad_idx == 3'(ei), {req, " bad_idx"}, rx_bad_idx, ei);
    check(rx_hard_reset == eh, {req, " R10 hard reset"}, rx_hard_reset, eh);
    @(negedge clk);
    check(rx_det_valid == 0 && rx_hard_reset == 0 && rx_type == 3'(et), {req, " R5 hold"}, rx_type, et);
  endtask

  task automatic test_reset();
    check(tx_busy == 0 && tx_done == 0 && tx_kcode == 0, "R12 tx reset", {tx_busy, tx_done}, 0);
    check(rx_det_valid == 0 && rx_type == 7 && rx_partial == 0 && rx_bad_idx == 0 && rx_hard_reset == 0,
          "R12 rx reset", rx_type, 7);
  endtask

  task automatic test_tx_none();
    @(negedge clk); tx_start = 1; tx_type = 3'd7;
    @(negedge clk); tx_start = 0;
    check(tx_busy == 0 && tx_kcode == 0, "R4 type 7 ignored", tx_busy, 0);
  endtask

  task automatic test_clear();
    @(negedge clk); rx_sym_valid = 1; rx_sym = EOP;
    @(negedge clk); rx_sym = R1;
    @(negedge clk); rx_sym_valid = 0; rx_clear = 1;
    @(negedge clk); rx_clear = 0;
    send_rx(S1, S1, S1, S2, 0, 0, 0, 0, "R11 clear");
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    for (int t = 0; t < 7; t++) send_tx(t);
    test_tx_none();
    for (int t = 0; t < 7; t++)
      send_rx(seq_code(t,0), seq_code(t,1), seq_code(t,2), seq_code(t,3), t, 0, 0, t == 6, "R6 exact");
    send_rx(S1, S1, S1, EOP, 0, 1, 3, 0, "R7 bad last");
    send_rx(EOP, S1, S3, S3, 1, 1, 0, 0, "R7 bad first");
    send_rx(S1, S1, S1, S3, 0, 1, 3, 0, "R8 tie lowest");
    send_rx(R1, R1, R1, EOP, 6, 1, 3, 1, "R10 partial hard");
    rx_enable = 9'h1fe;
    send_rx(S1, S1, S1, S3, 1, 1, 2, 0, "R9 mask fallback");
    rx_enable = 9'h1bf;
    send_rx(R1, R1, R1, R2, 7, 0, 0, 0, "R9 R10 hard masked");
    rx_enable = 9'h07f;
    send_rx(S1, S3, S1, S3, 2, 0, 0, 0, "R9 upper bits");
    send_rx(EOP, EOP, EOP, EOP, 7, 0, 0, 0, "R9 none");
    rx_enable = 9'h1ff;
    test_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule